// File: doc/BRIEF.md
# Debug Register File Access Unit

This block holds the debug-register state of a processor core: a bank of breakpoint address registers, a status register that records which breakpoint conditions fired, and a control register that configures them. Software reaches all of them through a single request port that carries a 3-bit register index, a write flag and write data. Reads return data one cycle after the request is accepted. Writes to status and control always force certain bits to one.

Indices 4 and 5 are alias slots, and their meaning depends on the `dbg_ext_en` input. With extensions off, 4 reaches the status register and 5 reaches the control register. With extensions on, any access to either index is illegal. An illegal access completes nothing: the block emits a one-cycle `fault_pulse` instead of a read response, and no state changes.

The address registers and the status and control values are exported in parallel to the matcher logic. The matchers report back through a hit vector, which replaces the low status bits, and through a single-step event, which sets the step bit.

The request port is a valid/ready interface. A request transfers on a rising clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low while reset is held and for the first cycle after it, and high from then on; the block never stalls an accepted stream. The read response is a plain one-cycle `rsp_valid` strobe with no back-pressure, so the requester must be able to take it.

Top module: `dbg_regfile_unit`

## Requirements
- R1: After reset the status register reads 0xFFFF0FF0, the control register reads 0x00000400, every address register reads 0, and neither `rsp_valid` nor `fault_pulse` is asserted.
- R2: Indices 0 to 3 write and read address registers 0 to 3 directly with no bit modification, in any extension mode.
- R3: A write to index 6 stores the write data ORed with 0xFFFF0FF0 in the status register.
- R4: A write to index 7 stores the write data ORed with 0x00000400 in the control register.
- R5: With `dbg_ext_en` low, index 4 reads and writes the status register and index 5 reads and writes the control register, with the same fixed-one rules.
- R6: With `dbg_ext_en` high, any accepted read or write to index 4 or 5 raises `fault_pulse` for exactly one cycle, in the cycle after acceptance. It produces no `rsp_valid` and changes no register.
- R7: An accepted legal read asserts `rsp_valid` for one cycle in the cycle after acceptance, with the register value as it stood before that edge. Writes never assert `rsp_valid`.
- R8: When `hit_valid` is high, status bits [3:0] are replaced by `hit_vec` (bit i is address register i) and all other status bits are kept.
- R9: When `step_evt` is high, status bit 14 is set and all other status bits are kept, apart from any hit update in the same cycle.
- R10: When a status write and a hit or step event fall in the same cycle, the write value (with its fixed ones) is applied first and the event is then merged on top.
- R11: `req_ready` is low during reset. A request presented with `req_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_ext_en | input | 1 | Debug extensions enable; makes indices 4 and 5 illegal |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_index | input | 3 | Register index 0..7 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| fault_pulse | output | 1 | One-cycle illegal-access fault |
| hit_valid | input | 1 | Hit vector update strobe |
| hit_vec | input | 4 | Breakpoint hit bits for status [3:0] |
| step_evt | input | 1 | Single-step event, sets status bit 14 |
| addr_regs | output | 128 | Address registers, register i at bits [32i+31:32i] |
| status_q | output | 32 | Current status register |
| control_q | output | 32 | Current control register |

## Verification
A wrong register value appears on the exported `addr_regs`, `status_q` or `control_q` buses in the cycle after the offending edge. The same value can be read back one cycle later on `rsp_rdata`. A broken index decode shows up in one of two ways. One is a missing or spurious `fault_pulse` in the cycle after acceptance. The other is a write that lands in the wrong register, so the bench sweeps every index in both extension modes and compares every exported register after each access. A lost fixed-one bit or a mishandled event merge is visible on `status_q` one edge after the event.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned IDX_W      = 3;
  localparam logic [XLEN-1:0] STATUS_ONES  = 32'hFFFF_0FF0;
  localparam logic [XLEN-1:0] CONTROL_ONES = 32'h0000_0400;
  localparam int unsigned STEP_BIT   = 14;

  typedef enum logic [1:0] {
    TGT_ADDR    = 2'd0,
    TGT_STATUS  = 2'd1,
    TGT_CONTROL = 2'd2,
    TGT_ILLEGAL = 2'd3
  } dbg_target_e;
endpackage

// File: rtl/dbg_index_decode.sv
module dbg_index_decode
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4,
  localparam int unsigned SEL_W = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
  input  logic [IDX_W-1:0] index,
  input  logic             ext_en,
  output dbg_target_e      target,
  output logic [SEL_W-1:0] addr_sel
);
  always_comb begin
    addr_sel = index[SEL_W-1:0];
    unique case (index)
      3'd4:    target = ext_en ? TGT_ILLEGAL : TGT_STATUS;
      3'd5:    target = ext_en ? TGT_ILLEGAL : TGT_CONTROL;
      3'd6:    target = TGT_STATUS;
      3'd7:    target = TGT_CONTROL;
      default: target = (int'(index) < NUM_ADDR) ? TGT_ADDR : TGT_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/dbg_addr_bank.sv
module dbg_addr_bank
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4,
  parameter int unsigned W        = XLEN,
  localparam int unsigned SEL_W = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [W-1:0]          wr_data,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [W-1:0]          rd_data,
  output logic [NUM_ADDR*W-1:0] flat_q
);
  logic [W-1:0] regs [NUM_ADDR];

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (int'(wr_sel) == g))
        regs[g] <= wr_data;
    end
    assign flat_q[g*W +: W] = regs[g];
  end

  assign rd_data = regs[rd_sel];
endmodule

// File: rtl/dbg_status_ctrl.sv
module dbg_status_ctrl
  import dbg_pkg::*;
#(
  parameter int unsigned HIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_status,
  input  logic             wr_control,
  input  logic [XLEN-1:0]  wdata,
  input  logic             hit_valid,
  input  logic [HIT_W-1:0] hit_vec,
  input  logic             step_evt,
  output logic [XLEN-1:0]  status_q,
  output logic [XLEN-1:0]  control_q
);
  logic [XLEN-1:0] status_d;

  // write first, then hardware events merged on top
  always_comb begin
    status_d = wr_status ? (wdata | STATUS_ONES) : status_q;
    if (hit_valid)
      status_d[HIT_W-1:0] = hit_vec;
    if (step_evt)
      status_d[STEP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= STATUS_ONES;
      control_q <= CONTROL_ONES;
    end else begin
      status_q <= status_d;
      if (wr_control)
        control_q <= wdata | CONTROL_ONES;
    end
  end
endmodule

// File: rtl/dbg_regfile_unit.sv
module dbg_regfile_unit
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4,
  localparam int unsigned SEL_W = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dbg_ext_en,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [IDX_W-1:0]         req_index,
  input  logic [XLEN-1:0]          req_wdata,
  output logic                     rsp_valid,
  output logic [XLEN-1:0]          rsp_rdata,
  output logic                     fault_pulse,
  input  logic                     hit_valid,
  input  logic [NUM_ADDR-1:0]      hit_vec,
  input  logic                     step_evt,
  output logic [NUM_ADDR*XLEN-1:0] addr_regs,
  output logic [XLEN-1:0]          status_q,
  output logic [XLEN-1:0]          control_q
);
  dbg_target_e      target;
  logic [SEL_W-1:0] addr_sel;
  logic             ready_q;
  logic             accept;
  logic [XLEN-1:0]  bank_rd;
  logic [XLEN-1:0]  rd_mux;

  dbg_index_decode #(.NUM_ADDR(NUM_ADDR)) u_decode (
    .index    (req_index),
    .ext_en   (dbg_ext_en),
    .target   (target),
    .addr_sel (addr_sel)
  );

  assign accept    = req_valid && ready_q;
  assign req_ready = ready_q;

  dbg_addr_bank #(.NUM_ADDR(NUM_ADDR), .W(XLEN)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && req_write && (target == TGT_ADDR)),
    .wr_sel  (addr_sel),
    .wr_data (req_wdata),
    .rd_sel  (addr_sel),
    .rd_data (bank_rd),
    .flat_q  (addr_regs)
  );

  dbg_status_ctrl #(.HIT_W(NUM_ADDR)) u_stctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_status  (accept && req_write && (target == TGT_STATUS)),
    .wr_control (accept && req_write && (target == TGT_CONTROL)),
    .wdata      (req_wdata),
    .hit_valid  (hit_valid),
    .hit_vec    (hit_vec),
    .step_evt   (step_evt),
    .status_q   (status_q),
    .control_q  (control_q)
  );

  always_comb begin
    unique case (target)
      TGT_ADDR:    rd_mux = bank_rd;
      TGT_STATUS:  rd_mux = status_q;
      TGT_CONTROL: rd_mux = control_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      fault_pulse <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid   <= accept && !req_write && (target != TGT_ILLEGAL);
      fault_pulse <= accept && (target == TGT_ILLEGAL);
      if (accept && !req_write && (target != TGT_ILLEGAL))
        rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dbg_regfile_chk.sv
module dbg_regfile_chk
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic                     rsp_valid,
  input logic                     fault_pulse,
  input logic                     hit_valid,
  input logic [NUM_ADDR-1:0]      hit_vec,
  input logic                     step_evt,
  input logic [NUM_ADDR*XLEN-1:0] addr_regs,
  input logic [XLEN-1:0]          status_q,
  input logic [XLEN-1:0]          control_q
);
  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_pulse && rsp_valid));

  // R6
  fault_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> ($stable(control_q) && $stable(addr_regs)));

  // R6
  fault_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pulse && !$past(hit_valid) && !$past(step_evt)) |-> $stable(status_q));

  // R3
  status_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & STATUS_ONES) == STATUS_ONES);

  // R4
  control_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (control_q & CONTROL_ONES) == CONTROL_ONES);

  // R7
  rsp_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R8
  hit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_valid) |-> (status_q[NUM_ADDR-1:0] == $past(hit_vec)));

  // R9
  step_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_evt) |-> status_q[STEP_BIT]);
endmodule

bind dbg_regfile_unit dbg_regfile_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .fault_pulse (fault_pulse),
  .hit_valid   (hit_valid),
  .hit_vec     (hit_vec),
  .step_evt    (step_evt),
  .addr_regs   (addr_regs),
  .status_q    (status_q),
  .control_q   (control_q)
);

// File: tb/test_dbg_regfile_unit.sv
module test_dbg_regfile_unit;
  localparam logic [31:0] SMASK = 32'hFFFF_0FF0;
  localparam logic [31:0] CMASK = 32'h0000_0400;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dbg_ext_en = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [2:0]   req_index = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         fault_pulse;
  logic         hit_valid = 1'b0;
  logic [3:0]   hit_vec = '0;
  logic         step_evt = 1'b0;
  logic [127:0] addr_regs;
  logic [31:0]  status_q;
  logic [31:0]  control_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] m_addr [4];
  logic [31:0] m_st, m_ct;

  always #5 clk = ~clk;

  dbg_regfile_unit i_dbg_regfile_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    for (int k = 0; k < 4; k++) chk(tag, addr_regs[k*32 +: 32], m_addr[k]);
    chk(tag, status_q, m_st);
    chk(tag, control_q, m_ct);
  endtask

  function automatic bit is_fault(input int idx, input bit ext);
    return ext && (idx == 4 || idx == 5);
  endfunction

  function automatic logic [31:0] model_read(input int idx, input bit ext);
    if (idx < 4) return m_addr[idx];
    if (idx == 6 || (idx == 4 && !ext)) return m_st;
    return m_ct;
  endfunction

  task automatic model_write(input int idx, input bit ext, input logic [31:0] d);
    if (is_fault(idx, ext)) return;
    if (idx < 4) m_addr[idx] = d;
    else if (idx == 6 || idx == 4) m_st = d | SMASK;
    else m_ct = d | CMASK;
  endtask

  // drive at negedge; the next negedge follows the accepting edge
  task automatic access(input bit wr, input int idx, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_index = 3'(idx); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_addr[k] = '0;
    m_st = SMASK; m_ct = CMASK;
    repeat (3) @(negedge clk);
    chk("R11 ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 fault", 32'(fault_pulse), 32'd0);
    chk_state("R1 reset state");

    // R11: write strobe without valid
    req_valid = 1'b0; req_write = 1'b1; req_index = 3'd0; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    chk_state("R11 no valid no effect");
    chk("R11 no rsp", 32'(rsp_valid | fault_pulse), 32'd0);

    // exhaustive sweep: both modes, all indices, four patterns
    for (int ext = 0; ext < 2; ext++) begin
      dbg_ext_en = ext[0];
      for (int idx = 0; idx < 8; idx++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] d;
          logic [31:0] expr;
          bit f;
          d = (32'h1357_9BDF * 32'(p + 1)) ^ (32'(idx) << 8) ^ (p[0] ? 32'hFFFF_FFFF : 32'h0);
          f = is_fault(idx, ext[0]);
          access(1'b1, idx, d);
          model_write(idx, ext[0], d);
          chk(f ? "R6 write fault" : "R2 R3 R4 R5 write no fault", 32'(fault_pulse), 32'(f));
          chk("R7 write no rsp", 32'(rsp_valid), 32'd0);
          chk_state(f ? "R6 state unchanged" : "R2 R3 R4 R5 state after write");
          expr = model_read(idx, ext[0]);
          access(1'b0, idx, 32'h0);
          chk(f ? "R6 read fault" : "R7 read no fault", 32'(fault_pulse), 32'(f));
          chk(f ? "R6 read no rsp" : "R7 read rsp", 32'(rsp_valid), 32'(!f));
          if (!f) chk("R2 R5 R7 read data", rsp_rdata, expr);
          chk_state("R6 R7 read no change");
        end
      end
    end
    dbg_ext_en = 1'b0;

    // R8: hit vector sweep
    for (int h = 0; h < 16; h++) begin
      hit_valid = 1'b1; hit_vec = 4'(h);
      @(negedge clk);
      hit_valid = 1'b0;
      m_st = (m_st & ~32'hF) | 32'(h);
      chk("R8 hit update", status_q, m_st);
    end

    // R9: step from a clear bit 14
    access(1'b1, 6, 32'h0);
    m_st = SMASK;
    step_evt = 1'b1;
    @(negedge clk);
    step_evt = 1'b0;
    m_st = m_st | 32'h4000;
    chk("R9 step bit", status_q, m_st);

    // R10: write with hit and step in the same cycle
    hit_valid = 1'b1; hit_vec = 4'hA; step_evt = 1'b1;
    access(1'b1, 6, 32'h0);
    hit_valid = 1'b0; step_evt = 1'b0;
    m_st = 32'hFFFF_4FFA;
    chk("R10 write plus events", status_q, m_st);

    // R7: read sees value before a same-cycle hit
    hit_valid = 1'b1; hit_vec = 4'h3;
    access(1'b0, 6, 32'h0);
    hit_valid = 1'b0;
    chk("R7 read old value", rsp_rdata, m_st);
    m_st = (m_st & ~32'hF) | 32'h3;
    chk("R8 hit during read", status_q, m_st);

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) m_addr[k] = '0;
    m_st = SMASK; m_ct = CMASK;
    @(negedge clk);
    chk_state("R1 second reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule